// File: doc/BRIEF.md
# Bidirectional Record CRC Checker

This block checks 16-bit CRC protection on a stored record that can be read either front to back or back to front, as happens on a tape. A record is a data field followed by its CRC. The data field is sent most significant bit first, and the CRC follows uncomplemented with its top bit first. A record opens with a start pulse and closes with an end pulse. In between, each serial bit qualified by a valid strobe goes through a single shift engine.

The direction select is captured when the record opens. When the record is read forward, the engine divides by x^16 + x^15 + x^2 + 1. When it is read backward, every bit of the record arrives in the opposite order, starting with the lowest bit of the stored CRC. In that case the engine divides by the mirrored polynomial x^16 + x^14 + x + 1. In both directions the register starts at zero, and a good record leaves a zero residue. The verdict appears one cycle after the end pulse.

In forward generate mode, the block also sends out the CRC of the data it has just taken in. This stream is the 16 bits to append to the record.

Top module: `rec_crc_check`

## Requirements
- R1: After reset, crc_o is 0, pass_o is 0 and app_vld_o is 0.
- R2: A start pulse clears the register to 0. For each accepted bit, the update depends on the register's top bit. If that bit equals the incoming bit, the register shifts left by one with a 0 entering. Otherwise it shifts left and is XORed with the active polynomial's low 16 bits: 0x8005 forward, 0x4003 reverse. crc_o shows the register. The data "123456789" in ASCII, sent MSB first, gives 0xFEE8.
- R3: In forward direction (rev_i = 0 at start), a record is data sent MSB first followed by its CRC bits 15 down to 0. After such a record, pass_o is 1 in the cycle after the end pulse.
- R4: In reverse direction (rev_i = 1 at start), the same record is fed in fully reversed bit order: CRC bit 0 first, data MSB last. After that record, pass_o is 1 in the cycle after the end pulse.
- R5: A record with any single bit flipped gives pass_o = 0 after the end pulse, in either direction.
- R6: rev_i and gen_i are sampled only on the start pulse. Changes to them while a record is open have no effect on the result.
- R7: bit_vld_i is ignored while no record is open, and also in the cycle of a start pulse. crc_o stays unchanged in those cycles.
- R8: A bit whose valid strobe coincides with the end pulse is included in the verdict.
- R9: If gen_i = 1 and rev_i = 0 at start, the end pulse starts a 16-cycle burst beginning the next cycle. During the burst, app_vld_o = 1 and app_bit_o carries the record's CRC from bit 15 down to bit 0, after which app_vld_o returns to 0. With rev_i = 1, gen_i produces no burst.
- R10: pass_o is cleared by a start pulse. It changes only at a start pulse or one cycle after an end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Record-open pulse; captures rev_i and gen_i |
| end_i | input | 1 | Record-close pulse |
| rev_i | input | 1 | Direction select: 0 forward, 1 reverse |
| gen_i | input | 1 | Generate mode select (forward only) |
| bit_i | input | 1 | Serial record bit |
| bit_vld_i | input | 1 | Strobe qualifying bit_i |
| crc_o | output | 16 | Current CRC register |
| pass_o | output | 1 | Zero-residue verdict of the last closed record |
| app_bit_o | output | 1 | CRC bit to append, MSB first |
| app_vld_o | output | 1 | Qualifies app_bit_o |

## Verification
Records of 1 to 72 data bits are generated forward and then replayed fully mirrored. A design that kept the forward polynomial for reverse reads, or that mirrored only within bytes, would fail clean reverse records. Single flipped bits are placed at a different offset in each record, so a verdict stuck at pass is caught in both directions. The direction select is toggled in the middle of every record, which exposes a design that does not latch it at start. The bench also drives strobes outside a record and on the start cycle, drives a final bit on the end cycle, and checks that a reverse-mode generate request stays silent.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  // Low w bits of the reciprocal of x^w + p(x); w must not exceed 32.
  function automatic logic [31:0] mirror_poly(input logic [31:0] p, input int w);
    logic [32:0] full;
    logic [31:0] r;
    full = {1'b0, p} | (33'd1 << w);
    r    = '0;
    for (int i = 0; i < w; i++) begin
      r[i] = full[w-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_shift_engine.sv
module crc_shift_engine #(
  parameter int            W      = 16,
  parameter logic [W-1:0]  POLY_F = 16'h8005,
  parameter logic [W-1:0]  POLY_R = 16'h4003
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  input  logic         rev,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_nxt
);

  logic         fb;
  logic [W-1:0] poly;

  always_comb begin
    fb      = crc_q[W-1] ^ din;
    poly    = rev ? POLY_R : POLY_F;
    crc_nxt = crc_q;
    if (step) begin
      crc_nxt = {crc_q[W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else            crc_q <= crc_nxt;
  end

  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == '0));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(crc_q));

endmodule

// File: rtl/rec_framer.sv
module rec_framer
  import rcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic end_i,
  input  logic rev_i,
  input  logic gen_i,
  input  logic bit_vld_i,
  input  logic nxt_zero,
  output logic clr_o,
  output logic step_o,
  output logic rev_o,
  output logic load_o,
  output logic pass_o
);

  logic open_q;
  dir_e dir_q;
  logic gen_q;
  logic pass_q;
  logic close;

  assign clr_o  = start_i;
  assign step_o = bit_vld_i && open_q && !start_i;
  assign close  = end_i && open_q && !start_i;
  assign rev_o  = (dir_q == DIR_REV);
  assign load_o = close && gen_q && (dir_q == DIR_FWD);
  assign pass_o = pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      dir_q  <= DIR_FWD;
      gen_q  <= 1'b0;
      pass_q <= 1'b0;
    end else if (start_i) begin
      open_q <= 1'b1;
      dir_q  <= dir_e'(rev_i);
      gen_q  <= gen_i;
      pass_q <= 1'b0;
    end else if (close) begin
      open_q <= 1'b0;
      pass_q <= nxt_zero;
    end
  end

  a_r6_dir_held: assert property (@(posedge clk) disable iff (rst)
    (open_q && !start_i) |=> $stable(dir_q));

  a_r10_pass_clear: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !pass_q);

  a_r3_pass_after_close: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_q) |-> $past(end_i && open_q));

endmodule

// File: rtl/crc_append_ser.sv
module crc_append_ser #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] crc_in,
  output logic         bit_o,
  output logic         vld_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= crc_in;
      cnt_q <= CW'(W);
    end else if (cnt_q != '0) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign bit_o = sr_q[W-1];
  assign vld_o = (cnt_q != '0);

  a_r9_burst_needs_load: assert property (@(posedge clk) disable iff (rst)
    $rose(vld_o) |-> $past(load));

  a_r9_load_starts_burst: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> vld_o);

endmodule

// File: rtl/rec_crc_check.sv
module rec_crc_check #(
  parameter int                CRC_W    = 16,
  parameter logic [CRC_W-1:0]  POLY_FWD = 16'h8005
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             rev_i,
  input  logic             gen_i,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             pass_o,
  output logic             app_bit_o,
  output logic             app_vld_o
);

  localparam logic [31:0]      REV_FULL = rcc_pkg::mirror_poly(32'(POLY_FWD), CRC_W);
  localparam logic [CRC_W-1:0] POLY_REV = REV_FULL[CRC_W-1:0];

  logic             clr;
  logic             step;
  logic             rev;
  logic             load;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic             nxt_zero;

  assign nxt_zero = (crc_nxt == '0);
  assign crc_o    = crc_q;

  rec_framer u_framer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .end_i     (end_i),
    .rev_i     (rev_i),
    .gen_i     (gen_i),
    .bit_vld_i (bit_vld_i),
    .nxt_zero  (nxt_zero),
    .clr_o     (clr),
    .step_o    (step),
    .rev_o     (rev),
    .load_o    (load),
    .pass_o    (pass_o)
  );

  crc_shift_engine #(
    .W      (CRC_W),
    .POLY_F (POLY_FWD),
    .POLY_R (POLY_REV)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .step    (step),
    .din     (bit_i),
    .rev     (rev),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  crc_append_ser #(
    .W (CRC_W)
  ) u_ser (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load   (load),
    .crc_in (crc_nxt),
    .bit_o  (app_bit_o),
    .vld_o  (app_vld_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (crc_o == '0 && !pass_o && !app_vld_o));

endmodule

// File: tb/rec_crc_check_test.sv
`timescale 1ns/100ps
module rec_crc_check_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 0, end_i = 0, rev_i = 0, gen_i = 0, bit_i = 0, bit_vld_i = 0;
  logic [15:0] crc_o;
  logic        pass_o, app_bit_o, app_vld_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rec_crc_check uut (
    .clk(clk), .rst(rst), .start_i(start_i), .end_i(end_i), .rev_i(rev_i),
    .gen_i(gen_i), .bit_i(bit_i), .bit_vld_i(bit_vld_i), .crc_o(crc_o),
    .pass_o(pass_o), .app_bit_o(app_bit_o), .app_vld_o(app_vld_o)
  );

  localparam int NV = 8;
  localparam logic [79:0] VEC_DATA [0:NV-1] = '{
    80'h313233343536373839, 80'h00, 80'h1, 80'hFFFF,
    80'hDEADBEEF, 80'h1A5B, 80'h0123456789, 80'hA5A50F0F3C3C9966
  };
  localparam int VEC_LEN [0:NV-1] = '{72, 8, 1, 16, 32, 13, 40, 64};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_crc(input logic [79:0] d, input int n);
    logic [15:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (c[15] == d[i]) c = {c[14:0], 1'b0};
      else               c = {c[14:0], 1'b0} ^ 16'h8005;
    end
    return c;
  endfunction

  function automatic logic cw_bit(input logic [79:0] d, input int n, input logic [15:0] c, input int k);
    if (k < n) return d[n-1-k];
    return c[15-(k-n)];
  endfunction

  task automatic open_rec(input bit rev, input bit gen);
    @(negedge clk);
    start_i = 1; rev_i = rev; gen_i = gen; bit_vld_i = 0; end_i = 0;
    @(negedge clk);
    start_i = 0;
  endtask

  // Feeds one record; returns at the negedge after the end pulse was taken.
  task automatic run_rec(input bit rev, input bit gen, input logic [79:0] d, input int n,
                         input logic [15:0] c, input bit with_crc, input int flip, input bit end_last);
    int total;
    total = n + (with_crc ? 16 : 0);
    open_rec(rev, gen);
    for (int i = 0; i < total; i++) begin
      int k;
      k = rev ? (total - 1 - i) : i;
      @(negedge clk);
      bit_vld_i = 1;
      bit_i     = cw_bit(d, n, c, k) ^ (k == flip);
      end_i     = (i == total - 1) && end_last;
      if (i == total / 2) begin
        rev_i = ~rev_i;
        gen_i = ~gen_i;
      end
    end
    if (!end_last) begin
      @(negedge clk);
      bit_vld_i = 0; end_i = 1;
    end
    @(negedge clk);
    bit_vld_i = 0; end_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, word, hold;
    bit          allv;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(crc_o == 0 && !pass_o && !app_vld_o, "R1 reset", {crc_o, 3'b0, pass_o, 3'b0, app_vld_o}, 0);

    for (int v = 0; v < NV; v++) begin
      c = model_crc(VEC_DATA[v], VEC_LEN[v]);
      if (v == 0) check(c == 16'hFEE8, "R2 model check value", c, 16'hFEE8);
      // generate pass (forward)
      run_rec(0, 1, VEC_DATA[v], VEC_LEN[v], 16'h0, 0, -1, 0);
      check(crc_o == c, "R2 data crc", crc_o, c);
      word = '0; allv = 1;
      for (int j = 15; j >= 0; j--) begin
        if (j != 15) @(negedge clk);
        word[j] = app_bit_o;
        allv = allv & app_vld_o;
      end
      check(allv && word == c, "R9 append burst", {15'b0, allv, word}, {16'h1, c});
      @(negedge clk);
      check(!app_vld_o, "R9 burst end", {31'b0, app_vld_o}, 0);
      // forward check, alternating end placement (R8)
      run_rec(0, 0, VEC_DATA[v], VEC_LEN[v], c, 1, -1, v[0]);
      check(pass_o, "R3 forward pass / R8 end bit", {31'b0, pass_o}, 1);
      // reverse check
      run_rec(1, 0, VEC_DATA[v], VEC_LEN[v], c, 1, -1, ~v[0]);
      check(pass_o, "R4 reverse pass / R6 held dir", {31'b0, pass_o}, 1);
      // single-bit errors
      run_rec(0, 0, VEC_DATA[v], VEC_LEN[v], c, 1, (v * 7) % (VEC_LEN[v] + 16), 0);
      check(!pass_o, "R5 forward flip", {31'b0, pass_o}, 0);
      run_rec(1, 0, VEC_DATA[v], VEC_LEN[v], c, 1, (v * 5 + 3) % (VEC_LEN[v] + 16), 0);
      check(!pass_o, "R5 reverse flip", {31'b0, pass_o}, 0);
    end

    // R7: strobes outside a record leave crc_o alone
    run_rec(0, 0, 80'hDEADBEEF, 32, 16'h0, 0, -1, 0);
    hold = crc_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bit_vld_i = 1; bit_i = i[0];
    end
    @(negedge clk); bit_vld_i = 0;
    check(crc_o == hold, "R7 closed strobes ignored", crc_o, hold);
    // R7: bit on start cycle dropped
    @(negedge clk); start_i = 1; rev_i = 0; gen_i = 0; bit_vld_i = 1; bit_i = 1;
    @(negedge clk); start_i = 0; bit_vld_i = 0;
    check(crc_o == 0, "R7 start-cycle bit dropped", crc_o, 0);
    @(negedge clk); end_i = 1;
    @(negedge clk); end_i = 0;
    check(pass_o, "R3 empty record passes", {31'b0, pass_o}, 1);

    // R10: start clears pass
    open_rec(0, 0);
    check(!pass_o, "R10 start clears pass", {31'b0, pass_o}, 0);
    @(negedge clk); end_i = 1;
    @(negedge clk); end_i = 0;

    // R9: generate request in reverse stays silent
    run_rec(1, 1, 80'h1A5B, 13, 16'h0, 0, -1, 0);
    allv = 0;
    for (int i = 0; i < 18; i++) begin
      allv = allv | app_vld_o;
      @(negedge clk);
    end
    check(!allv, "R9 no burst in reverse", {31'b0, allv}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule